// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This block is the internal data memory of an 8-bit microcontroller core. It turns an operand reference into either a RAM byte or a special function register (SFR) access. Three reference modes exist: a register number (0 to 7) within the active bank, a direct 8-bit address, and an indirect reference through register 0 or register 1 of the active bank. The active bank is a 2-bit value taken from bits 4:3 of a status byte. Switching the bank moves the eight register references onto a different group of bytes, so interrupt code can switch banks instead of saving registers to a stack.

The upper 128 addresses are shared. A direct reference there goes out on the SFR port to the peripherals. An indirect reference there reaches upper RAM. The RAM holds either 128 or 256 bytes, set by a parameter. In the 128-byte build, indirect references to the upper half find no memory.

The core sees one read port and one write port. Both can be used in the same cycle. A read is registered and appears on `rd_data` after the clock edge that samples it.

Top module: `iram_unit`

## Requirements
- R1: After reset, `rd_data` is 0 and every RAM byte reads as 0.
- R2: A register-mode reference (mode 0) with register number n = `sel[2:0]` reaches the RAM byte at bank×8 + n, where bank = `status[4:3]`. Read data appears on `rd_data` one clock after the edge that samples `rd_en`.
- R3: A direct reference (mode 1) to an address below 0x80 reaches the same RAM byte, so register n of bank b is also reachable at direct address b×8 + n.
- R4: An indirect reference (mode 2) uses `sel[0]` to choose register 0 or register 1 of the active bank as the address. If a write to that pointer happens in the same cycle, the value the pointer held before the write is used.
- R5: A direct read at 0x80 or above drives `sfr_re`, with `sfr_raddr` set to the address. `rd_data` then becomes `sfr_rdata` when `sfr_rhit` is 1, and 0 when it is not.
- R6: A direct write at 0x80 or above drives `sfr_we`, with `sfr_waddr` and `sfr_wdata`, only when `sfr_whit` is 1. Such a write never changes RAM.
- R7: An indirect reference to 0x80 or above reaches upper RAM and never raises `sfr_re` or `sfr_we`.
- R8: With RAM_BYTES = 128, an indirect read at 0x80 or above returns 0. An indirect write there changes no byte, and in particular does not alias into the lower half.
- R9: When a read and a write reach the same RAM byte in one cycle, the read returns the new write data.
- R10: The same register number in different banks reaches different bytes.
- R11: Mode 3 reaches nothing. A read in mode 3 returns 0, and a write in mode 3 changes no RAM byte and raises no SFR strobe.
- R12: While `rd_en` is 0, `rd_data` holds its last value, even if a write changes the byte that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| status | input | 8 | Status byte; bits 4:3 hold the active bank |
| rd_en | input | 1 | Read request |
| rd_mode | input | 2 | Read mode: 0 register, 1 direct, 2 indirect, 3 none |
| rd_sel | input | 8 | Register number, direct address, or pointer select (bit 0) |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Write request |
| wr_mode | input | 2 | Write mode, encoded as for rd_mode |
| wr_sel | input | 8 | Write reference, encoded as for rd_sel |
| wr_data | input | 8 | Write data |
| sfr_raddr | output | 8 | SFR read address |
| sfr_re | output | 1 | SFR read strobe |
| sfr_rdata | input | 8 | SFR read data from the peripherals |
| sfr_rhit | input | 1 | Peripheral implements sfr_raddr |
| sfr_waddr | output | 8 | SFR write address |
| sfr_we | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_whit | input | 1 | Peripheral implements sfr_waddr |

## Verification
Most faults in the address resolution show up on `rd_data` one cycle after the read that hits the wrong byte. These include using the wrong bank bits, fetching the pointer from the wrong bank, and confusing the upper RAM with the SFR space. The bench therefore writes distinct values through one mode and reads them back through another. A RAM byte that was corrupted silently stays hidden until a later read reaches it, so every test reads back the neighbouring bytes it could have hit. SFR strobe faults are visible on the same cycle as the request, and the bench samples them there.

// File: rtl/iram_unit.sv
module iram_unit #(
  parameter int RAM_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] status,
  input  logic       rd_en,
  input  logic [1:0] rd_mode,
  input  logic [7:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       wr_en,
  input  logic [1:0] wr_mode,
  input  logic [7:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sfr_raddr,
  output logic       sfr_re,
  input  logic [7:0] sfr_rdata,
  input  logic       sfr_rhit,
  output logic [7:0] sfr_waddr,
  output logic       sfr_we,
  output logic [7:0] sfr_wdata,
  input  logic       sfr_whit
);
  localparam int AW = (RAM_BYTES > 128) ? 8 : 7;
  localparam logic HAS_UPPER = (RAM_BYTES > 128);
  localparam logic [1:0] M_REG = 2'd0, M_DIR = 2'd1, M_IND = 2'd2;

  logic [7:0] mem [RAM_BYTES];
  logic [1:0] bank;
  logic [7:0] r_ptr, w_ptr, r_addr, w_addr;
  logic       r_ram, w_ram, r_sfr;

  assign bank  = status[4:3];
  assign r_ptr = mem[AW'({3'b000, bank, 2'b00, rd_sel[0]})];
  assign w_ptr = mem[AW'({3'b000, bank, 2'b00, wr_sel[0]})];

  function automatic logic [7:0] resolve(input logic [1:0] m, input logic [7:0] s,
                                         input logic [7:0] p, input logic [1:0] b);
    case (m)
      M_REG:   resolve = {3'b000, b, s[2:0]};
      M_IND:   resolve = p;
      default: resolve = s;
    endcase
  endfunction

  function automatic logic hits_ram(input logic [1:0] m, input logic [7:0] a);
    hits_ram = (m == M_REG) || (m == M_DIR && !a[7]) || (m == M_IND && (HAS_UPPER || !a[7]));
  endfunction

  assign r_addr = resolve(rd_mode, rd_sel, r_ptr, bank);
  assign w_addr = resolve(wr_mode, wr_sel, w_ptr, bank);
  assign r_ram  = rd_en && hits_ram(rd_mode, r_addr);
  assign w_ram  = wr_en && hits_ram(wr_mode, w_addr);
  assign r_sfr  = rd_en && rd_mode == M_DIR && rd_sel[7];

  assign sfr_raddr = rd_sel;
  assign sfr_re    = r_sfr;
  assign sfr_waddr = wr_sel;
  assign sfr_wdata = wr_data;
  assign sfr_we    = wr_en && wr_mode == M_DIR && wr_sel[7] && sfr_whit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      for (int i = 0; i < RAM_BYTES; i++) mem[i] <= '0;
    end else begin
      if (w_ram) mem[w_addr[AW-1:0]] <= wr_data;
      if (rd_en) begin
        if (r_sfr)
          rd_data <= sfr_rhit ? sfr_rdata : 8'h00;
        else if (r_ram)
          rd_data <= (w_ram && w_addr == r_addr) ? wr_data : mem[r_addr[AW-1:0]];
        else
          rd_data <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/iram_unit_chk.sv
module iram_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [1:0] rd_mode,
  input logic [7:0] rd_sel,
  input logic [7:0] rd_data,
  input logic       wr_en,
  input logic [1:0] wr_mode,
  input logic [7:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       sfr_re,
  input logic [7:0] sfr_rdata,
  input logic       sfr_rhit,
  input logic       sfr_we,
  input logic       sfr_whit
);
  assert_sfr_hit_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_re && sfr_rhit) |=> rd_data == $past(sfr_rdata));

  assert_sfr_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_re && !sfr_rhit) |=> rd_data == 8'h00);

  assert_sfr_write_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> sfr_whit);

  assert_indirect_no_sfr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2 || rd_mode == 2'd3) |-> !sfr_re);

  assert_bypass_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_mode == 2'd0 && wr_mode == 2'd0 && rd_sel[2:0] == wr_sel[2:0])
    |=> rd_data == $past(wr_data));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind iram_unit iram_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_mode(rd_mode), .rd_sel(rd_sel),
  .rd_data(rd_data), .wr_en(wr_en), .wr_mode(wr_mode), .wr_sel(wr_sel),
  .wr_data(wr_data), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata), .sfr_rhit(sfr_rhit),
  .sfr_we(sfr_we), .sfr_whit(sfr_whit)
);

// File: tb/iram_unit_test.sv
module iram_unit_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] status = 0;
  logic rd_en = 0, wr_en = 0;
  logic [1:0] rd_mode = 0, wr_mode = 0;
  logic [7:0] rd_sel = 0, wr_sel = 0, wr_data = 0;
  logic [7:0] rd_data, rd_data_s;
  logic [7:0] sfr_raddr, sfr_rdata, sfr_waddr, sfr_wdata;
  logic sfr_re, sfr_rhit, sfr_we, sfr_whit;
  logic [7:0] s_raddr, s_rdata, s_waddr, s_wdata;
  logic s_re, s_rhit, s_we, s_whit;

  always #(CLK_P/2) clk = ~clk;

  assign sfr_rhit  = sfr_raddr[7:4] == 4'h9;
  assign sfr_rdata = sfr_raddr ^ 8'h5A;
  assign sfr_whit  = sfr_waddr[7:4] == 4'h9;
  assign s_rhit    = s_raddr[7:4] == 4'h9;
  assign s_rdata   = s_raddr ^ 8'h5A;
  assign s_whit    = s_waddr[7:4] == 4'h9;

  iram_unit #(.RAM_BYTES(256)) uut (
    .clk(clk), .rst_n(rst_n), .status(status), .rd_en(rd_en), .rd_mode(rd_mode),
    .rd_sel(rd_sel), .rd_data(rd_data), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_sel(wr_sel), .wr_data(wr_data), .sfr_raddr(sfr_raddr), .sfr_re(sfr_re),
    .sfr_rdata(sfr_rdata), .sfr_rhit(sfr_rhit), .sfr_waddr(sfr_waddr),
    .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_whit(sfr_whit));

  iram_unit #(.RAM_BYTES(128)) uut_small (
    .clk(clk), .rst_n(rst_n), .status(status), .rd_en(rd_en), .rd_mode(rd_mode),
    .rd_sel(rd_sel), .rd_data(rd_data_s), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_sel(wr_sel), .wr_data(wr_data), .sfr_raddr(s_raddr), .sfr_re(s_re),
    .sfr_rdata(s_rdata), .sfr_rhit(s_rhit), .sfr_waddr(s_waddr),
    .sfr_we(s_we), .sfr_wdata(s_wdata), .sfr_whit(s_whit));

  typedef struct { logic [7:0] exp; logic [7:0] exp_s; string tag; } item_t;
  item_t q[$];

  logic [7:0] big [256];
  logic [7:0] sml [128];
  logic [7:0] last_exp = 0, last_exp_s = 0;
  logic [1:0] cur_bank = 0;
  logic cap_re, cap_we;
  int checks = 0, fails = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [1:0] m, input logic [7:0] s, output logic [7:0] a);
    a = s;
    case (m)
      2'd0: begin a = {3'b000, cur_bank, s[2:0]}; return 1; end
      2'd1: return s[7] ? 2 : 1;
      2'd2: begin a = big[{3'b000, cur_bank, 2'b00, s[0]}]; return 3; end
      default: return 0;
    endcase
  endfunction

  task automatic op(input logic re, input logic [1:0] rm, input logic [7:0] rs,
                    input logic we, input logic [1:0] wm, input logic [7:0] ws,
                    input logic [7:0] wd, input string tag);
    item_t it;
    int rk, wk;
    logic [7:0] ra, wa;
    logic wbig, wsml;
    @(negedge clk);
    status = {3'b000, cur_bank, 3'b000};
    rd_en = re; rd_mode = rm; rd_sel = rs;
    wr_en = we; wr_mode = wm; wr_sel = ws; wr_data = wd;
    rk = kind_of(rm, rs, ra);
    wk = kind_of(wm, ws, wa);
    wbig = we && (wk == 1 || wk == 3);
    wsml = we && (wk == 1 || (wk == 3 && !wa[7]));
    if (!re) begin
      it.exp = last_exp; it.exp_s = last_exp_s;
    end else if (rk == 2) begin
      it.exp = (ra[7:4] == 4'h9) ? (ra ^ 8'h5A) : 8'h00;
      it.exp_s = it.exp;
    end else if (rk == 1 || rk == 3) begin
      it.exp = (wbig && wa == ra) ? wd : big[ra];
      if (rk == 3 && ra[7]) it.exp_s = 8'h00;
      else it.exp_s = (wsml && wa == ra) ? wd : sml[ra[6:0]];
    end else begin
      it.exp = 8'h00; it.exp_s = 8'h00;
    end
    it.tag = tag;
    if (wbig) big[wa] = wd;
    if (wsml) sml[wa[6:0]] = wd;
    last_exp = it.exp; last_exp_s = it.exp_s;
    #1;
    cap_re = sfr_re; cap_we = sfr_we;
    @(posedge clk);
    q.push_back(it);
  endtask

  task automatic rd(input logic [1:0] m, input logic [7:0] s, input string tag);
    op(1, m, s, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [1:0] m, input logic [7:0] s, input logic [7:0] d, input string tag);
    op(0, 0, 0, 1, m, s, d, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(rd_data, it.exp, {it.tag, " (256-byte)"});
        chk(rd_data_s, it.exp_s, {it.tag, " (128-byte)"});
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) big[i] = 0;
    for (int i = 0; i < 128; i++) sml[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data, 8'h00, "R1 rd_data after reset");

    for (int n = 0; n < 8; n++) rd(0, 8'(n), "R1 reset register");
    rd(1, 8'h7F, "R1 reset direct");
    for (int n = 0; n < 8; n++) wr(0, 8'(n), 8'h10 + 8'(n), "R2 write");
    for (int n = 0; n < 8; n++) rd(0, 8'(n), "R2 register readback");

    cur_bank = 2;
    wr(0, 8'd3, 8'hC3, "R10 write bank2");
    rd(0, 8'd3, "R10 read bank2");
    cur_bank = 0;
    rd(0, 8'd3, "R10 bank0 untouched");
    rd(1, 8'h13, "R3 direct alias of bank2 r3");
    wr(1, 8'h0A, 8'h77, "R3 direct write");
    cur_bank = 1;
    rd(0, 8'd2, "R3 register view of direct write");

    cur_bank = 0;
    wr(1, 8'h05, 8'h55, "R8 lower guard byte");
    wr(0, 8'd0, 8'h40, "R4 set pointer");
    wr(2, 8'd0, 8'h99, "R4 indirect write");
    rd(1, 8'h40, "R4 direct view of indirect write");
    wr(0, 8'd1, 8'h85, "R7 set upper pointer");
    wr(2, 8'd1, 8'hAB, "R7 indirect upper write");
    chk({7'd0, cap_re | cap_we}, 8'h00, "R7 no SFR strobe on indirect write");
    rd(2, 8'd1, "R7 R8 indirect upper read");
    chk({7'd0, cap_re | cap_we}, 8'h00, "R7 no SFR strobe on indirect read");
    rd(1, 8'h05, "R8 no alias into lower half");
    rd(1, 8'h85, "R5 direct upper unimplemented SFR");
    chk({7'd0, cap_re}, 8'h01, "R5 sfr_re raised");
    rd(1, 8'h93, "R5 direct upper implemented SFR");

    wr(1, 8'h92, 8'hEE, "R6 implemented SFR write");
    chk({7'd0, cap_we}, 8'h01, "R6 sfr_we raised");
    wr(1, 8'hB0, 8'hEE, "R6 unimplemented SFR write");
    chk({7'd0, cap_we}, 8'h00, "R6 sfr_we suppressed");
    wr(0, 8'd1, 8'h92, "R6 point at upper 0x92");
    rd(2, 8'd1, "R6 upper RAM untouched by SFR write");

    op(1, 0, 8'd5, 1, 0, 8'd5, 8'h3C, "R9 bypass register");
    op(1, 1, 8'h40, 1, 2, 8'd0, 8'h5D, "R9 bypass indirect vs direct");
    op(1, 2, 8'd0, 1, 0, 8'd0, 8'h22, "R4 old pointer used");
    rd(2, 8'd0, "R4 new pointer used");

    wr(3, 8'h05, 8'hFF, "R11 mode3 write");
    chk({7'd0, cap_re | cap_we}, 8'h00, "R11 no strobe in mode3");
    rd(3, 8'h05, "R11 mode3 read");
    rd(1, 8'h05, "R11 byte unchanged");
    rd(1, 8'h0F, "R11 register byte unchanged");

    rd(0, 8'd5, "R12 prime");
    op(0, 0, 0, 1, 0, 8'd5, 8'h01, "R12 hold with write");
    op(0, 0, 0, 0, 0, 0, 0, "R12 hold idle");

    for (int b = 0; b < 4; b++) begin
      cur_bank = 2'(b);
      for (int n = 0; n < 8; n++) wr(0, 8'(n), 8'(b * 37 + n * 11 + 1), "R2 sweep write");
    end
    cur_bank = 3;
    for (int a = 0; a < 32; a++) rd(1, 8'(a), "R2 R3 sweep direct readback");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule